// File: doc/BRIEF.md
# Numeric Fault Interrupt Handshake

This block turns a numeric-coprocessor error level from the processor into an internal interrupt request line (the legacy IRQ13 level) and an ignore-error output. Software answers the interrupt by performing any I/O write to the acknowledge port. That write withdraws the interrupt request and hands over to the ignore-error output. The ignore output then holds until the processor withdraws its error level. The whole function is gated by an enable bit.

The error level may arrive from another clock domain, so it passes through a parameterised synchroniser before it drives the control state. The ignore output is additionally qualified by the raw error pin. It therefore can never be seen high while the pin is low, whatever the synchroniser depth.

Top module: `numeric_fault_irq`

## Requirements
- R1: After reset both `irq13_o` and `ignore_o` are low.
- R2: With `enable_i` high, a high level on `fault_i` raises `irq13_o` exactly SYNC_STAGES+1 rising edges after it is first sampled.
- R3: An I/O write (`io_wr_i` high) to address ACK_ADDR (default 0x00F0) while `irq13_o` is high and the error is still present lowers `irq13_o` and raises `ignore_o` on the next edge.
- R4: `ignore_o` stays high for as long as `fault_i` stays high and `enable_i` stays high.
- R5: `ignore_o` is low in every cycle in which `fault_i` is low, including the cycle of the falling edge itself.
- R6: Once the synchronised error has fallen and the block has returned to idle, a new high level on `fault_i` raises `irq13_o` again.
- R7: A write to any address other than ACK_ADDR, or a read (write strobe low) at ACK_ADDR, leaves both outputs unchanged.
- R8: A write to ACK_ADDR while `irq13_o` is low has no effect on either output.
- R9: While `enable_i` is low, both outputs are low in that same cycle, and a high `fault_i` raises nothing.
- R10: Once raised, `irq13_o` stays high until the acknowledge write, even if `fault_i` falls first. An acknowledge whose synchronised error is already low returns the block to idle without raising `ignore_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Function enable; low forces both outputs low |
| fault_i | input | 1 | Numeric error level from the processor, active high |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_addr_i | input | ADDR_W | I/O address of the write |
| irq13_o | output | 1 | Internal interrupt request level |
| ignore_o | output | 1 | Ignore-numeric-error level |

## Verification
The bench builds the block with SYNC_STAGES=2, ADDR_W=16 and ACK_ADDR=0x00F0, so the synchroniser delay is visible in every raise and drop of the error. This makes it possible to reach the windows where the raw pin and the synchronised level disagree: the pin has already fallen while the state still shows the ignore phase, and an acknowledge arrives after the pin fell but before the control state saw it. Acknowledge writes are placed on the matching address, on a neighbouring address and with the strobe low, in each of the three control phases.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    typedef enum logic [1:0] {
        NFE_IDLE = 2'd0,
        NFE_PEND = 2'd1,
        NFE_IGN  = 2'd2
    } nfe_state_e;

    typedef struct packed {
        nfe_state_e phase;
    } nfe_regs_t;

endpackage

// File: rtl/nfe_sync.sv
module nfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb begin
                chain_d = chain_q;
                chain_d[0] = async_i;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= chain_d;
            end

            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/nfe_ack_decode.sv
module nfe_ack_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] ACK_ADDR = 16'h00F0
) (
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    output logic              ack_o
);
    always_comb begin
        ack_o = io_wr_i && (io_addr_i == ACK_ADDR);
    end
endmodule

// File: rtl/nfe_ctrl.sv
module nfe_ctrl
    import nfe_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic fault_sync_i,
    input  logic fault_raw_i,
    input  logic ack_i,
    output logic irq_o,
    output logic ignore_o
);
    nfe_regs_t r_d;
    nfe_regs_t r_q;

    always_comb begin
        r_d = r_q;
        if (!enable_i) begin
            r_d.phase = NFE_IDLE;
        end else begin
            unique case (r_q.phase)
                NFE_IDLE: if (fault_sync_i) r_d.phase = NFE_PEND;
                NFE_PEND: if (ack_i)        r_d.phase = fault_sync_i ? NFE_IGN : NFE_IDLE;
                NFE_IGN:  if (!fault_sync_i) r_d.phase = NFE_IDLE;
                default:                    r_d.phase = NFE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{phase: NFE_IDLE};
        else         r_q <= r_d;
    end

    always_comb begin
        irq_o    = enable_i && (r_q.phase == NFE_PEND);
        ignore_o = enable_i && (r_q.phase == NFE_IGN) && fault_sync_i && fault_raw_i;
    end

    // R3
    ack_hands_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && ack_i && fault_sync_i && enable_i) |=> (r_q.phase == NFE_IGN));

    // R8
    idle_ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.phase == NFE_IDLE && !fault_sync_i) |=> (r_q.phase == NFE_IDLE));

    // R9
    disable_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_i) |=> (r_q.phase == NFE_IDLE));

    // R10
    pend_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.phase == NFE_PEND && enable_i && !ack_i) |=> (r_q.phase == NFE_PEND));

    // R2
    pend_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.phase == NFE_IDLE && enable_i && fault_sync_i) |=> (r_q.phase == NFE_PEND));
endmodule

// File: rtl/numeric_fault_irq.sv
module numeric_fault_irq #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] ACK_ADDR    = 16'h00F0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              fault_i,
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    output logic              irq13_o,
    output logic              ignore_o
);
    logic fault_sync;
    logic ack_hit;

    nfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (fault_i),
        .sync_o  (fault_sync)
    );

    nfe_ack_decode #(.ADDR_W(ADDR_W), .ACK_ADDR(ACK_ADDR)) u_dec (
        .io_wr_i   (io_wr_i),
        .io_addr_i (io_addr_i),
        .ack_o     (ack_hit)
    );

    nfe_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enable_i     (enable_i),
        .fault_sync_i (fault_sync),
        .fault_raw_i  (fault_i),
        .ack_i        (ack_hit),
        .irq_o        (irq13_o),
        .ignore_o     (ignore_o)
    );

    // R5
    ignore_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ignore_o |-> fault_i);

    // R3
    outputs_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq13_o && ignore_o));

    // R7
    foreign_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq13_o && enable_i && !ack_hit) |=> irq13_o || !enable_i);
endmodule

// File: tb/numeric_fault_irq_bench.sv
module numeric_fault_irq_bench;
    localparam int          ADDR_W = 16;
    localparam logic [15:0] ACK    = 16'h00F0;
    localparam int          SYNC   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic flt = 1'b0;
    logic wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic irq, ign;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural reference
    int hist[$];
    int m_phase = 0; // 0 idle, 1 pending, 2 ignoring

    always #4 clk = ~clk;

    numeric_fault_irq #(.ADDR_W(ADDR_W), .ACK_ADDR(ACK), .SYNC_STAGES(SYNC)) u_numeric_fault_irq (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .fault_i(flt),
        .io_wr_i(wr), .io_addr_i(addr), .irq13_o(irq), .ignore_o(ign)
    );

    function automatic int synced();
        return hist[SYNC-1];
    endfunction

    task automatic model_edge();
        int s;
        bit hit;
        s = synced();
        hit = wr && (addr == ACK);
        if (!rst_n) m_phase = 0;
        else if (!en) m_phase = 0;
        else if (m_phase == 0 && s == 1) m_phase = 1;
        else if (m_phase == 1 && hit) m_phase = (s == 1) ? 2 : 0;
        else if (m_phase == 2 && s == 0) m_phase = 0;
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) hist[i] = 0;
        end else begin
            hist.push_front(int'(flt));
            void'(hist.pop_back());
        end
    endtask

    task automatic compare();
        bit e_irq, e_ign;
        e_irq = en && m_phase == 1;
        e_ign = en && m_phase == 2 && synced() == 1 && flt;
        total++;
        if (irq !== e_irq || ign !== e_ign) begin
            bad++;
            $display("FAIL %s: irq=%b ign=%b expected irq=%b ign=%b at %0t",
                     tag, irq, ign, e_irq, e_ign, $time);
        end
    endtask

    // one clock: edge, model, sample, then apply next inputs
    task automatic step(input logic n_en, input logic n_flt, input logic n_wr, input logic [15:0] n_addr);
        @(posedge clk);
        model_edge();
        #1;
        compare();
        en = n_en; flt = n_flt; wr = n_wr; addr = n_addr;
        #1;
        compare(); // combinational view of the new inputs
    endtask

    task automatic idle_n(input int n, input logic e, input logic f);
        for (int i = 0; i < n; i++) step(e, f, 1'b0, 16'h0);
    endtask

    initial begin
        for (int i = 0; i < SYNC; i++) hist.push_back(0);
        #1;
        total++;
        if (irq !== 1'b0 || ign !== 1'b0) begin
            bad++;
            $display("FAIL R1: irq=%b ign=%b expected 0 0", irq, ign);
        end
        tag = "R1";
        idle_n(3, 1'b1, 1'b0);
        rst_n = 1'b1;
        idle_n(3, 1'b1, 1'b0);

        tag = "R2";
        idle_n(6, 1'b1, 1'b1);
        tag = "R7";
        step(1'b1, 1'b1, 1'b1, 16'h00F1);
        step(1'b1, 1'b1, 1'b0, ACK);
        step(1'b1, 1'b1, 1'b1, 16'h01F0);
        idle_n(2, 1'b1, 1'b1);
        tag = "R3";
        step(1'b1, 1'b1, 1'b1, ACK);
        tag = "R4";
        idle_n(8, 1'b1, 1'b1);
        tag = "R8";
        step(1'b1, 1'b1, 1'b1, ACK);
        idle_n(2, 1'b1, 1'b1);
        tag = "R5";
        idle_n(6, 1'b1, 1'b0);
        tag = "R8";
        step(1'b1, 1'b0, 1'b1, ACK);
        idle_n(3, 1'b1, 1'b0);

        tag = "R6";
        idle_n(6, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1, ACK);
        idle_n(3, 1'b1, 1'b1);
        idle_n(5, 1'b1, 1'b0);

        tag = "R10";
        idle_n(5, 1'b1, 1'b1);
        idle_n(6, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, ACK);
        idle_n(4, 1'b1, 1'b0);

        tag = "R9";
        idle_n(5, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 16'h0);
        idle_n(6, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1, ACK);
        idle_n(3, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1, ACK);
        idle_n(3, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 16'h0);
        idle_n(3, 1'b0, 1'b0);

        tag = "R5";
        idle_n(4, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1, ACK);
        idle_n(2, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0, 16'h0);
        step(1'b1, 1'b1, 1'b0, 16'h0);
        idle_n(6, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule